// File: doc/BRIEF.md
# Back-to-Back Instruction Dependency Checker

This block decides whether an instruction issued directly after another one must wait for it. It receives a decoded operand summary of both instructions. For the older instruction, the summary gives its destination kind, its destination register and whether it writes the condition flag. For the younger instruction, it gives its destination kind and register, up to three source operands and whether it reads the flag. A single bit comes back: set means the younger instruction depends on the older one. The block does no decoding of its own.

A register that forms an address is treated as a source in every position, including the base of a memory-addressed destination. Any memory-addressed write followed by any memory-addressed read is ordered unconditionally, so a store always drains before a load. A flag producer followed by a flag consumer is always a dependency.

When the parameter `PIPE` is 1 (the default), the result comes out of a register one clock after the inputs. When it is 0, the result is combinational.

Top module: `dep_check`

## Requirements
- R1: When the older instruction writes the flag (`prevFlagWr`=1) and the younger reads it (`nextFlagRd`=1), the result is 1, whatever the operand fields hold.
- R2: When the older destination kind is none (code 0) and the flag pair of R1 is absent, the result is 0 for any younger operands.
- R3: A younger source whose kind is immediate (code 0), or the unused code 3, never creates a dependency, even when its register field equals the older destination register.
- R4: A younger register-direct source (code 1) creates a dependency when its 5-bit register number equals `prevDstReg` and the older destination kind is register direct (1) or memory addressed (2). Source i occupies kind bits [2i+1:2i] and register bits [5i+4:5i].
- R5: A younger displacement source (code 2) creates a dependency when its base register equals `prevDstReg` under the same older destination kinds as R4.
- R6: When the younger destination kind is memory addressed (2), its base register `nextDstReg` is compared like a source. A register-direct younger destination (1) is never compared.
- R7: When the older destination is memory addressed (2) and any younger source is memory addressed (2), the result is 1 regardless of register numbers.
- R8: An older destination of kind flag (3) takes part in no register comparison. Only R1 can then produce a 1.
- R9: With `PIPE`=1, `depHit` shows the result for the inputs present at the previous rising clock edge, and it is 0 while `rstN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only when PIPE=1 |
| rstN | input | 1 | Active-low synchronous reset of the result register |
| prevDstKind | input | 2 | Older destination kind: 0 none, 1 register, 2 memory, 3 flag |
| prevDstReg | input | REGW | Older destination register, or address base for kind 2 |
| prevFlagWr | input | 1 | Older instruction writes the flag |
| nextDstKind | input | 2 | Younger destination kind, same coding |
| nextDstReg | input | REGW | Younger destination register, or address base for kind 2 |
| nextSrcKind | input | 2*NSRC | Younger source kinds: 0 immediate, 1 register, 2 memory, 3 unused |
| nextSrcReg | input | REGW*NSRC | Younger source register numbers or address bases |
| nextFlagRd | input | 1 | Younger instruction reads the flag |
| depHit | output | 1 | 1 when the younger instruction depends on the older |

## Verification
Directed pairs each isolate one rule. A flag pair sits over unrelated registers. Equal register numbers are hidden behind immediate, unused-code, flag-kind and register-direct-destination fields, and they must not trip the checker. Each source slot is matched in turn, and a load follows a store with different registers, so each path that forces a 1 is observed on its own. A stream of pseudo-random descriptor pairs, with register numbers drawn from a small set so matches are frequent, then exercises combinations of the rules. A separate probe reads the output between a new input and the next clock edge to tell the registered result from a combinational one.

// File: rtl/dep_pkg.sv
package dep_pkg;
  localparam logic [1:0] DST_NONE = 2'd0;
  localparam logic [1:0] DST_REG  = 2'd1;
  localparam logic [1:0] DST_MEM  = 2'd2;
  localparam logic [1:0] DST_FLAG = 2'd3;

  localparam logic [1:0] SRC_IMM  = 2'd0;
  localparam logic [1:0] SRC_REG  = 2'd1;
  localparam logic [1:0] SRC_MEM  = 2'd2;

  localparam int KIND_W = 2;

  typedef struct packed {
    logic flagHazard;   // flag written then read
    logic regCmpEn;     // older instruction has a register-numbered destination
    logic prevIsMem;    // older destination is memory addressed
    logic nextDstBase;  // younger destination base register acts as a source
  } depStrobe_t;
endpackage

// File: rtl/dep_ctrl.sv
module dep_ctrl
  import dep_pkg::*;
(
  input  logic [1:0] prevDstKind,
  input  logic       prevFlagWr,
  input  logic [1:0] nextDstKind,
  input  logic       nextFlagRd,
  output depStrobe_t strobes
);
  always_comb begin
    strobes.flagHazard  = prevFlagWr && nextFlagRd;
    strobes.regCmpEn    = (prevDstKind == DST_REG) || (prevDstKind == DST_MEM);
    strobes.prevIsMem   = (prevDstKind == DST_MEM);
    strobes.nextDstBase = (nextDstKind == DST_MEM);
  end
endmodule

// File: rtl/dep_dpath.sv
module dep_dpath
  import dep_pkg::*;
#(
  parameter int NSRC = 3,
  parameter int REGW = 5,
  parameter bit PIPE = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  depStrobe_t             strobes,
  input  logic [REGW-1:0]        prevDstReg,
  input  logic [REGW-1:0]        nextDstReg,
  input  logic [NSRC*KIND_W-1:0] nextSrcKind,
  input  logic [NSRC*REGW-1:0]   nextSrcReg,
  output logic                   depNow,
  output logic                   depHit
);
  logic [NSRC-1:0] srcHit;
  logic [NSRC-1:0] srcIsMem;
  logic [NSRC-1:0] srcIsImm;
  logic            baseHit;
  logic            regHit;
  logic            orderHit;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [KIND_W-1:0] kindI;
    logic [REGW-1:0]   regI;
    logic              readsReg;
    assign kindI       = nextSrcKind[i*KIND_W +: KIND_W];
    assign regI        = nextSrcReg[i*REGW +: REGW];
    assign readsReg    = (kindI == SRC_REG) || (kindI == SRC_MEM);
    assign srcHit[i]   = readsReg && (regI == prevDstReg);
    assign srcIsMem[i] = (kindI == SRC_MEM);
    assign srcIsImm[i] = !readsReg;
  end

  assign baseHit  = strobes.nextDstBase && (nextDstReg == prevDstReg);
  assign regHit   = strobes.regCmpEn && ((|srcHit) || baseHit);
  assign orderHit = strobes.prevIsMem && (|srcIsMem);
  assign depNow   = strobes.flagHazard || regHit || orderHit;

  if (PIPE) begin : g_pipe
    logic depQ;
    always_ff @(posedge clk) begin
      if (!rstN) depQ <= 1'b0;
      else       depQ <= depNow;
    end
    assign depHit = depQ;
  end else begin : g_comb
    assign depHit = depNow;
  end

  AST_IMM_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((&srcIsImm) && !strobes.nextDstBase && !strobes.flagHazard) |-> !depNow); // R3
endmodule

// File: rtl/dep_check.sv
module dep_check
  import dep_pkg::*;
#(
  parameter int NSRC = 3,
  parameter int REGW = 5,
  parameter bit PIPE = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             prevDstKind,
  input  logic [REGW-1:0]        prevDstReg,
  input  logic                   prevFlagWr,
  input  logic [1:0]             nextDstKind,
  input  logic [REGW-1:0]        nextDstReg,
  input  logic [NSRC*2-1:0]      nextSrcKind,
  input  logic [NSRC*REGW-1:0]   nextSrcReg,
  input  logic                   nextFlagRd,
  output logic                   depHit
);
  depStrobe_t strobes;
  logic       depNow;

  dep_ctrl u_ctrl (
    .prevDstKind(prevDstKind),
    .prevFlagWr (prevFlagWr),
    .nextDstKind(nextDstKind),
    .nextFlagRd (nextFlagRd),
    .strobes    (strobes)
  );

  dep_dpath #(.NSRC(NSRC), .REGW(REGW), .PIPE(PIPE)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .prevDstReg (prevDstReg),
    .nextDstReg (nextDstReg),
    .nextSrcKind(nextSrcKind),
    .nextSrcReg (nextSrcReg),
    .depNow     (depNow),
    .depHit     (depHit)
  );

  logic anyMemSrc;
  always_comb begin
    anyMemSrc = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (nextSrcKind[i*2 +: 2] == SRC_MEM) anyMemSrc = 1'b1;
  end

  AST_FLAG_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (prevFlagWr && nextFlagRd) |-> depNow); // R1
  AST_NO_DEST: assert property (@(posedge clk) disable iff (!rstN)
    ((prevDstKind == DST_NONE) && !(prevFlagWr && nextFlagRd)) |-> !depNow); // R2
  AST_BASE_DEST: assert property (@(posedge clk) disable iff (!rstN)
    ((nextDstKind == DST_MEM) && (nextDstReg == prevDstReg) &&
     ((prevDstKind == DST_REG) || (prevDstKind == DST_MEM))) |-> depNow); // R6
  AST_MEM_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    ((prevDstKind == DST_MEM) && anyMemSrc) |-> depNow); // R7
  AST_FLAG_DEST: assert property (@(posedge clk) disable iff (!rstN)
    ((prevDstKind == DST_FLAG) && !(prevFlagWr && nextFlagRd)) |-> !depNow); // R8
endmodule

// File: tb/sim_dep_check.sv
module sim_dep_check;
  localparam int NSRC = 3;
  localparam int REGW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0]           prevDstKind = '0;
  logic [REGW-1:0]      prevDstReg = '0;
  logic                 prevFlagWr = 1'b0;
  logic [1:0]           nextDstKind = '0;
  logic [REGW-1:0]      nextDstReg = '0;
  logic [NSRC*2-1:0]    nextSrcKind = '0;
  logic [NSRC*REGW-1:0] nextSrcReg = '0;
  logic                 nextFlagRd = 1'b0;
  logic                 depHit;

  always #10 clk = ~clk;  // 50 MHz

  dep_check #(.NSRC(NSRC), .REGW(REGW), .PIPE(1'b1)) u0 (
    .clk(clk), .rstN(rstN),
    .prevDstKind(prevDstKind), .prevDstReg(prevDstReg), .prevFlagWr(prevFlagWr),
    .nextDstKind(nextDstKind), .nextDstReg(nextDstReg),
    .nextSrcKind(nextSrcKind), .nextSrcReg(nextSrcReg),
    .nextFlagRd(nextFlagRd), .depHit(depHit)
  );

  typedef struct { bit exp; string tag; } item_t;
  item_t sbq[$];
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  function automatic bit model(logic [1:0] pk, logic [4:0] pr, logic pfw,
                               logic [1:0] nk, logic [4:0] nr,
                               logic [5:0] nsk, logic [14:0] nsr, logic nfr);
    if (pfw && nfr) return 1'b1;
    if (pk == 2'd0 || pk == 2'd3) return 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (pk == 2'd2 && nsk[2*i +: 2] == 2'd2) return 1'b1;
      if ((nsk[2*i +: 2] == 2'd1 || nsk[2*i +: 2] == 2'd2) && nsr[5*i +: 5] == pr)
        return 1'b1;
    end
    if (nk == 2'd2 && nr == pr) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(bit act, bit exp, string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: depHit=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic drive(string tag, logic [1:0] pk, logic [4:0] pr, logic pfw,
                       logic [1:0] nk, logic [4:0] nr,
                       logic [5:0] nsk, logic [14:0] nsr, logic nfr);
    item_t it;
    @(negedge clk);
    prevDstKind = pk; prevDstReg = pr; prevFlagWr = pfw;
    nextDstKind = nk; nextDstReg = nr; nextSrcKind = nsk;
    nextSrcReg = nsr; nextFlagRd = nfr;
    it.exp = model(pk, pr, pfw, nk, nr, nsk, nsr, nfr);
    it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor: result registered at the edge after driving, sampled mid high phase
  always @(posedge clk) begin
    #5;
    if (rstN && sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      check(depHit, it.exp, it.tag);
    end
  end

  function automatic logic [14:0] regs(logic [4:0] a, logic [4:0] b, logic [4:0] c);
    return {c, b, a};
  endfunction

  function automatic logic [5:0] kinds(logic [1:0] a, logic [1:0] b, logic [1:0] c);
    return {c, b, a};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(depHit, 1'b0, "R9 reset value");
    prevFlagWr = 1'b1; nextFlagRd = 1'b1;
    @(negedge clk);
    check(depHit, 1'b0, "R9 held low during reset");
    rstN = 1'b1;

    drive("R1 flag pair", 2'd0, 5'd3, 1'b1, 2'd1, 5'd9, kinds(0,0,0), regs(1,2,4), 1'b1);
    drive("R1 flag write only", 2'd0, 5'd3, 1'b1, 2'd1, 5'd9, kinds(0,0,0), regs(1,2,4), 1'b0);
    drive("R2 no older dest", 2'd0, 5'd3, 1'b0, 2'd2, 5'd3, kinds(1,2,1), regs(3,3,3), 1'b0);
    drive("R3 immediates", 2'd1, 5'd7, 1'b0, 2'd1, 5'd7, kinds(0,0,0), regs(7,7,7), 1'b0);
    drive("R3 unused code", 2'd1, 5'd7, 1'b0, 2'd0, 5'd0, kinds(3,3,3), regs(7,7,7), 1'b0);
    drive("R4 slot0 match", 2'd1, 5'd7, 1'b0, 2'd1, 5'd1, kinds(1,0,0), regs(7,0,0), 1'b0);
    drive("R4 slot1 match", 2'd1, 5'd7, 1'b0, 2'd1, 5'd1, kinds(1,1,1), regs(6,7,8), 1'b0);
    drive("R4 no match", 2'd1, 5'd7, 1'b0, 2'd1, 5'd1, kinds(1,1,1), regs(6,8,9), 1'b0);
    drive("R5 base slot2", 2'd1, 5'd12, 1'b0, 2'd1, 5'd2, kinds(0,1,2), regs(1,2,12), 1'b0);
    drive("R6 mem dest base", 2'd1, 5'd4, 1'b0, 2'd2, 5'd4, kinds(0,0,0), regs(0,0,0), 1'b0);
    drive("R6 reg dest ignored", 2'd1, 5'd4, 1'b0, 2'd1, 5'd4, kinds(0,0,0), regs(0,0,0), 1'b0);
    drive("R7 store then load", 2'd2, 5'd1, 1'b0, 2'd1, 5'd3, kinds(0,2,0), regs(0,20,0), 1'b0);
    drive("R7 store then reg", 2'd2, 5'd1, 1'b0, 2'd1, 5'd3, kinds(1,0,0), regs(20,0,0), 1'b0);
    drive("R5 older mem base match", 2'd2, 5'd9, 1'b0, 2'd0, 5'd0, kinds(1,0,0), regs(9,0,0), 1'b0);
    drive("R8 flag dest", 2'd3, 5'd5, 1'b0, 2'd2, 5'd5, kinds(1,2,1), regs(5,5,5), 1'b0);
    drive("R8 flag dest with pair", 2'd3, 5'd5, 1'b1, 2'd0, 5'd0, kinds(0,0,0), regs(0,0,0), 1'b1);

    // R9 latency probe: output must not follow the new inputs before the edge
    drive("R9 zero before probe", 2'd0, 5'd0, 1'b0, 2'd0, 5'd0, kinds(0,0,0), regs(0,0,0), 1'b0);
    drive("R9 one at probe", 2'd0, 5'd0, 1'b1, 2'd0, 5'd0, kinds(0,0,0), regs(0,0,0), 1'b1);
    #5;
    check(depHit, 1'b0, "R9 registered latency");

    for (int n = 0; n < 60; n++) begin
      logic [1:0] pk, nk;
      logic [5:0] nsk;
      logic [14:0] nsr;
      pk  = 2'($urandom_range(0, 3));
      nk  = 2'($urandom_range(0, 3));
      nsk = 6'($urandom);
      nsr = regs(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
                 5'($urandom_range(0, 3)));
      drive("R4 R5 R7 mixed", pk, 5'($urandom_range(0, 3)), 1'($urandom),
            nk, 5'($urandom_range(0, 3)), nsk, nsr, 1'($urandom));
    end

    repeat (4) @(negedge clk);
    if (sbq.size() != 0) check(1'b0, 1'b1, "R9 scoreboard drained");
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule